// File: doc/BRIEF.md
# Paged Host Register Interface

This block connects a non-multiplexed parallel host bus to a paged space of control and status registers. A five-bit host address and an eight-bit data bus reach up to 18 pages of 16 registers each. The address uses two steps. The top address bit selects either the internal page-select register or a 16-entry window into the page that is currently selected. A write to the page-select register chooses the page. Later accesses through the window use that page until a new page is written.

A strap input sets the strobe convention. In one setting the bus has separate read and write strobes. In the other it has a single read/write direction line and a data strobe. The block first brings all bus inputs through a synchronizer. It then detects the start of each write and gives the register storage four things: the decoded page, the register index, the write data, and a one-hot write enable. On reads it selects the byte that goes back to the host and drives an output-enable for the host data bus.

Top module: `paged_reg_if`

## Requirements
- R1: After reset the page is 0, no write enable is asserted, and the read output-enable is low.
- R2: A write with address bit 4 = 0 loads the page-select register from the data byte. Address bits 3..0 are ignored. The page is unchanged by any other access.
- R3: A page-select write whose data is 18 or more is ignored, and the previous page is kept.
- R4: A read with address bit 4 = 0 returns the current page number, zero-extended to 8 bits.
- R5: A write with address bit 4 = 1 asserts only write-enable bit page*16 + addr[3:0] and presents the data byte on reg_wdata_o. The page persists across any number of such writes.
- R6: A read with address bit 4 = 1 returns byte page*16 + addr[3:0] of reg_rdata_i, where byte n occupies bits 8n+7..8n.
- R7: A location whose bit is clear in the implemented-location mask reads as 0x00, and a write to it asserts no write enable.
- R8: With mode_i = 1, a write is cs_ni low with wr_rw_i low, and a read is cs_ni low with rd_ds_ni low.
- R9: With mode_i = 0, rd_ds_ni low with cs_ni low is the data strobe. wr_rw_i = 1 makes that a read and wr_rw_i = 0 makes it a write.
- R10: Each write strobe assertion gives one write-enable pulse exactly one clock long. The pulse appears two clock edges after the edge that first samples the asserted strobe. Read data and output-enable follow the sampled inputs with the same two-edge delay.
- R11: While cs_ni is high, no write enable is asserted and the output-enable stays low, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Strobe convention: 1 separate read/write, 0 direction plus data strobe |
| cs_ni | input | 1 | Chip select, active low |
| rd_ds_ni | input | 1 | Read strobe (mode 1) or data strobe (mode 0), active low |
| wr_rw_i | input | 1 | Write strobe active low (mode 1) or direction, 1 = read (mode 0) |
| addr_i | input | 5 | Host address; bit 4 picks page-select or register window |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| rdata_oe_o | output | 1 | Read in progress; enables the host data bus driver |
| page_o | output | 5 | Currently selected page |
| reg_idx_o | output | 4 | Register index within the page |
| reg_wdata_o | output | 8 | Write data toward the register storage |
| reg_we_o | output | 288 | One-hot write enable, bit page*16 + index |
| reg_rdata_i | input | 2304 | Flattened register contents, byte page*16 + index |

## Verification
The bench builds the block with the default 18 pages of 16 registers and a synchronizer two stages deep. It overrides the implemented-location mask so that the upper half of page 17 and register 15 of page 3 are absent. With that mask, the unimplemented-location rules can be checked on the last page, and the mask is known not to be indexed by the address alone. Both strobe conventions are exercised. Page-select writes at the boundary values 17, 18 and 20 show that out-of-range pages are rejected.

// File: rtl/paged_reg_pkg.sv
package paged_reg_pkg;
  typedef enum logic {
    STRB_DIR_DS = 1'b0,
    STRB_SPLIT  = 1'b1
  } strb_mode_e;

  function automatic logic wr_active(strb_mode_e m, logic cs_n, logic a_n, logic b);
    if (m == STRB_SPLIT) return !cs_n && !b;
    return !cs_n && !a_n && !b;
  endfunction

  function automatic logic rd_active(strb_mode_e m, logic cs_n, logic a_n, logic b);
    if (m == STRB_SPLIT) return !cs_n && !a_n;
    return !cs_n && !a_n && b;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import paged_reg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          rd_ds_ni,
  input  logic          wr_rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          wr_pulse_o,
  output logic          rd_act_o
);
  localparam int BW = 3 + AW + DW;
  localparam logic [BW-1:0] IDLE = {3'b111, {(AW+DW){1'b0}}};

  logic [BW-1:0] stg [SYNC_STAGES];
  logic          wr_act, wr_q;
  strb_mode_e    mode;

  assign mode = strb_mode_e'(mode_i);

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[g] <= IDLE;
      else if (g == 0) stg[g] <= {cs_ni, rd_ds_ni, wr_rw_i, addr_i, wdata_i};
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  logic s_cs_n, s_a_n, s_b;
  assign {s_cs_n, s_a_n, s_b, addr_o, wdata_o} = stg[SYNC_STAGES-1];

  assign wr_act   = wr_active(mode, s_cs_n, s_a_n, s_b);
  assign rd_act_o = rd_active(mode, s_cs_n, s_a_n, s_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_act;
  end

  assign wr_pulse_o = wr_act && !wr_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o); // R10
  AST_NO_STROBE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_cs_n |-> !wr_pulse_o && !rd_act_o); // R11
endmodule

// File: rtl/page_reg.sv
module page_reg #(
  parameter int NUM_PAGES = 18,
  parameter int PW = 5,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [PW-1:0] page_o
);
  localparam logic [DW-1:0] LIMIT = DW'(NUM_PAGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      page_o <= '0;
    else if (load_i && data_i < LIMIT) page_o <= data_i[PW-1:0];
  end

  always_ff @(posedge clk_i)
    if (rst_ni) AST_PAGE_RANGE: assert (int'(page_o) < NUM_PAGES); // R3

  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(page_o)); // R2
endmodule

// File: rtl/rd_mux.sv
module rd_mux #(
  parameter int NUM_PAGES = 18,
  parameter int PAGE_REGS = 16,
  parameter int PW = 5,
  parameter int IW = 4,
  parameter int DW = 8,
  parameter logic [NUM_PAGES*PAGE_REGS-1:0] IMPL_MASK = '1
) (
  input  logic                              win_i,
  input  logic [PW-1:0]                     page_i,
  input  logic [IW-1:0]                     idx_i,
  input  logic [NUM_PAGES*PAGE_REGS*DW-1:0] reg_rdata_i,
  output logic [DW-1:0]                     rdata_o
);
  always_comb begin
    int flat;
    flat = int'(page_i) * PAGE_REGS + int'(idx_i);
    if (!win_i)                rdata_o = DW'(page_i);
    else if (IMPL_MASK[flat])  rdata_o = reg_rdata_i[flat*DW +: DW];
    else                       rdata_o = '0;
  end
endmodule

// File: rtl/paged_reg_if.sv
module paged_reg_if #(
  parameter int NUM_PAGES = 18,
  parameter int PAGE_REGS = 16,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_PAGES*PAGE_REGS-1:0] IMPL_MASK = '1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  mode_i,
  input  logic                                  cs_ni,
  input  logic                                  rd_ds_ni,
  input  logic                                  wr_rw_i,
  input  logic [$clog2(PAGE_REGS):0]            addr_i,
  input  logic [DATA_W-1:0]                     wdata_i,
  output logic [DATA_W-1:0]                     rdata_o,
  output logic                                  rdata_oe_o,
  output logic [$clog2(NUM_PAGES)-1:0]          page_o,
  output logic [$clog2(PAGE_REGS)-1:0]          reg_idx_o,
  output logic [DATA_W-1:0]                     reg_wdata_o,
  output logic [NUM_PAGES*PAGE_REGS-1:0]        reg_we_o,
  input  logic [NUM_PAGES*PAGE_REGS*DATA_W-1:0] reg_rdata_i
);
  localparam int IW   = $clog2(PAGE_REGS);
  localparam int AW   = IW + 1;
  localparam int PW   = $clog2(NUM_PAGES);
  localparam int NTOT = NUM_PAGES * PAGE_REGS;

  logic [AW-1:0] addr_s;
  logic          wr_pulse, win;

  strobe_sync #(.AW(AW), .DW(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .cs_ni      (cs_ni),
    .rd_ds_ni   (rd_ds_ni),
    .wr_rw_i    (wr_rw_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .addr_o     (addr_s),
    .wdata_o    (reg_wdata_o),
    .wr_pulse_o (wr_pulse),
    .rd_act_o   (rdata_oe_o)
  );

  assign win       = addr_s[AW-1];
  assign reg_idx_o = addr_s[IW-1:0];

  page_reg #(.NUM_PAGES(NUM_PAGES), .PW(PW), .DW(DATA_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_pulse && !win),
    .data_i (reg_wdata_o),
    .page_o (page_o)
  );

  rd_mux #(
    .NUM_PAGES(NUM_PAGES), .PAGE_REGS(PAGE_REGS), .PW(PW), .IW(IW),
    .DW(DATA_W), .IMPL_MASK(IMPL_MASK)
  ) u_rd (
    .win_i       (win),
    .page_i      (page_o),
    .idx_i       (reg_idx_o),
    .reg_rdata_i (reg_rdata_i),
    .rdata_o     (rdata_o)
  );

  for (genvar g = 0; g < NTOT; g++) begin : g_we
    if (IMPL_MASK[g]) begin : g_impl
      assign reg_we_o[g] = wr_pulse && win &&
                           (int'(page_o) * PAGE_REGS + int'(reg_idx_o) == g);
    end else begin : g_absent
      assign reg_we_o[g] = 1'b0;
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we_o)); // R5
  AST_WE_PAGE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o != '0) |=> $stable(page_o)); // R5
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o != '0) |=> (reg_we_o == '0)); // R10
  AST_WE_IMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o & ~IMPL_MASK) == '0); // R7
endmodule

// File: tb/paged_reg_if_test.sv
module paged_reg_if_test;
  localparam int NP = 18, NR = 16, NT = NP * NR;

  function automatic bit impl(int p, int r);
    return !((p == 17 && r >= 8) || (p == 3 && r == 15));
  endfunction
  function automatic logic [NT-1:0] mk_mask();
    logic [NT-1:0] m;
    for (int i = 0; i < NT; i++) m[i] = impl(i / NR, i % NR);
    return m;
  endfunction
  function automatic logic [7:0] src_byte(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  localparam logic [NT-1:0] MASK = mk_mask();

  logic clk = 0, rst_n = 0;
  logic mode = 1, cs_n = 1, rd_ds_n = 1, wr_rw = 1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, reg_wdata;
  logic oe;
  logic [4:0] page;
  logic [3:0] idx;
  logic [NT-1:0] we;
  logic [NT*8-1:0] src;

  always #4 clk = ~clk;

  initial for (int i = 0; i < NT; i++) src[i*8 +: 8] = src_byte(i);

  paged_reg_if #(.IMPL_MASK(MASK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n),
    .rd_ds_ni(rd_ds_n), .wr_rw_i(wr_rw), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(oe), .page_o(page), .reg_idx_o(idx),
    .reg_wdata_o(reg_wdata), .reg_we_o(we), .reg_rdata_i(src)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model: queue of bus samples taken at each rising edge
  typedef struct packed {logic cs, a, b; logic [4:0] ad; logic [7:0] d;} snap_t;
  localparam snap_t IDLE = '{cs: 1, a: 1, b: 1, ad: 0, d: 0};
  snap_t hq[$];
  int m_page = 0;

  function automatic bit wact(snap_t s);
    return mode ? (!s.cs && !s.b) : (!s.cs && !s.a && !s.b);
  endfunction
  function automatic bit ract(snap_t s);
    return mode ? (!s.cs && !s.a) : (!s.cs && !s.a && s.b);
  endfunction
  function automatic bit pulse_now();
    return wact(hq[1]) && !wact(hq[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = '{IDLE, IDLE, IDLE};
      m_page = 0;
    end else begin
      if (pulse_now() && !hq[1].ad[4] && hq[1].d < 8'(NP)) m_page = int'(hq[1].d);
      hq.push_front('{cs: cs_n, a: rd_ds_n, b: wr_rw, ad: addr, d: wdata});
      void'(hq.pop_back());
    end
  end

  int we_cnt = 0, we_idx = -1;

  always @(negedge clk) if (rst_n) begin
    logic [NT-1:0] e_we;
    logic [7:0] e_rd;
    int fl;
    fl = m_page * NR + int'(hq[1].ad[3:0]);
    e_we = '0;
    if (pulse_now() && hq[1].ad[4] && impl(m_page, int'(hq[1].ad[3:0]))) e_we[fl] = 1'b1;
    if (!hq[1].ad[4]) e_rd = 8'(m_page);
    else e_rd = impl(m_page, int'(hq[1].ad[3:0])) ? src_byte(fl) : 8'h00;
    chk(we == e_we, "R5/R7/R10 write enable vector", $countones(we), $countones(e_we));
    chk(int'(page) == m_page, "R2/R3 page", int'(page), m_page);
    chk(oe == ract(hq[1]), "R8/R9 output enable", int'(oe), int'(ract(hq[1])));
    chk(rdata == e_rd, "R4/R6/R7 read data", int'(rdata), int'(e_rd));
    chk(reg_wdata == hq[1].d, "R5 write data", int'(reg_wdata), int'(hq[1].d));
    if (we != '0) begin
      we_cnt++;
      for (int i = 0; i < NT; i++) if (we[i]) we_idx = i;
    end
  end

  task automatic idle_bus();
    cs_n = 1; rd_ds_n = 1; wr_rw = 1;
  endtask

  task automatic acc(input bit wr, input logic [4:0] ad, input logic [7:0] d,
                     output logic [7:0] rd);
    @(negedge clk);
    addr = ad; wdata = d; cs_n = 0;
    if (mode) begin
      if (wr) wr_rw = 0; else rd_ds_n = 0;
    end else begin
      wr_rw = !wr; rd_ds_n = 0;
    end
    repeat (4) @(negedge clk);
    rd = rdata;
    idle_bus();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_acc(input logic [4:0] ad, input logic [7:0] d);
    logic [7:0] x;
    we_cnt = 0; we_idx = -1;
    acc(1, ad, d, x);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(page == 0 && we == '0 && !oe, "R1 reset state", int'(page), 0);

    // split strobes
    mode = 1;
    wr_acc(5'b00111, 8'd5);
    chk(page == 5, "R2 page load ignores low address bits", int'(page), 5);
    acc(0, 5'b01010, 8'h00, r);
    chk(r == 8'd5, "R4 page read back", int'(r), 5);
    wr_acc(5'h13, 8'hA5);
    chk(we_cnt == 1 && we_idx == 5*NR + 3, "R10 one pulse at page 5 reg 3", we_idx, 5*NR + 3);
    wr_acc(5'h1E, 8'h3C);
    chk(we_cnt == 1 && we_idx == 5*NR + 14, "R5 page persists", we_idx, 5*NR + 14);
    acc(0, 5'h19, 8'h00, r);
    chk(r == src_byte(5*NR + 9), "R6 R8 register read", int'(r), int'(src_byte(5*NR + 9)));
    wr_acc(5'h00, 8'd20);
    chk(page == 5, "R3 page 20 rejected", int'(page), 5);
    wr_acc(5'h00, 8'd18);
    chk(page == 5, "R3 page 18 rejected", int'(page), 5);
    wr_acc(5'h00, 8'd17);
    chk(page == 17, "R3 page 17 accepted", int'(page), 17);
    acc(0, 5'h1C, 8'h00, r);
    chk(r == 8'h00, "R7 unimplemented read", int'(r), 0);
    wr_acc(5'h1C, 8'hFF);
    chk(we_cnt == 0, "R7 unimplemented write", we_cnt, 0);
    acc(0, 5'h17, 8'h00, r);
    chk(r == src_byte(17*NR + 7), "R6 last page read", int'(r), int'(src_byte(17*NR + 7)));

    // direction plus data strobe
    mode = 0;
    @(negedge clk);
    wr_acc(5'h00, 8'd3);
    chk(page == 3, "R9 page write", int'(page), 3);
    wr_acc(5'h12, 8'h77);
    chk(we_cnt == 1 && we_idx == 3*NR + 2, "R9 register write", we_idx, 3*NR + 2);
    wr_acc(5'h1F, 8'h11);
    chk(we_cnt == 1 - 1, "R7 page 3 reg 15 absent", we_cnt, 0);
    acc(0, 5'h12, 8'h00, r);
    chk(r == src_byte(3*NR + 2), "R9 register read", int'(r), int'(src_byte(3*NR + 2)));

    // deselected strobes
    we_cnt = 0;
    @(negedge clk);
    addr = 5'h12; wdata = 8'h99; rd_ds_n = 0; wr_rw = 0;
    repeat (4) @(negedge clk);
    chk(!oe, "R11 no output enable while deselected", int'(oe), 0);
    idle_bus();
    repeat (4) @(negedge clk);
    chk(we_cnt == 0, "R11 no write while deselected", we_cnt, 0);
    mode = 1;
    @(negedge clk);
    rd_ds_n = 0;
    repeat (4) @(negedge clk);
    chk(!oe, "R11 split mode read deselected", int'(oe), 0);
    idle_bus();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule